// File: doc/BRIEF.md
# Multicycle Instruction Cycle Controller

This block is the control unit of a small accumulator machine. It steps through the register transfers among the program counter, memory address register, memory buffer register and instruction register. Each instruction passes through a short run of subcycles: fetch, an optional indirect subcycle, execute, and an interrupt subcycle when an interrupt is accepted. All memory traffic goes through one single-port synchronous memory port.

The 16-bit instruction word holds a 3-bit opcode in bits 15:13, an indirect flag in bit 12 and a 12-bit address in bits 11:0. Execute supports four opcodes:

- load the accumulator
- store the accumulator
- unconditional jump
- turn on interrupt acceptance

This is enough to drive every data path.

The interrupt subcycle writes the return address to a fixed save word and sends control to a fixed handler address. Both addresses are parameters.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: While reset is asserted and immediately after its release, `phase_o` reads 0 (fetch), and neither `mem_rd` nor `mem_wr` is high.
- R2: Fetch places the program counter on `mem_addr` with `mem_rd` high. The counter advances by one during the fetch, so an instruction that does not branch is followed by a fetch from the next address.
- R3: Read data on `mem_rdata` is taken exactly one cycle after the cycle in which `mem_rd` was high. There is no other wait.
- R4: When instruction bit 12 is set, an indirect subcycle runs between fetch and execute. It reads the word at address bits 11:0 and uses that word's low 12 bits as the effective address.
- R5: Opcode 0 loads the word at the effective address into the accumulator. Opcode 1 writes the accumulator to the effective address, with `mem_wr` high and the value on `mem_wdata`.
- R6: Opcode 2 makes the effective address the next fetch address.
- R7: A pending interrupt is taken only at the end of execute and only when interrupts are enabled. The interrupt subcycle writes the address of the next instruction to SAVE_ADDR. The following fetch then reads from HANDLER_ADDR.
- R8: Opcode 3 enables interrupts. The first check that can see the enable is at the end of the following instruction. Entering the interrupt subcycle disables interrupts again, so a request held high while interrupts are disabled has no effect.
- R9: `phase_o` encodes fetch=0, indirect=1, execute=2 and interrupt=3. Indirect is entered only from fetch, and execute only from fetch or indirect.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_pending | input | 1 | Level-sensitive interrupt request |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data is returned on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, driven from the buffer register |
| mem_rdata | input | 16 | Read data |
| phase_o | output | 2 | Current subcycle code |

## Verification
Any internal register error shows up in the port traffic within one instruction.

- A wrong program counter changes the address of the next fetch read.
- A wrong buffer or accumulator value shows up as wrong data on the next store write.
- A misrouted indirect address changes the address of the following read or write.

The subcycle code exposes the order of subcycles. A missed, spurious or mistimed interrupt therefore appears at the end of the execute subcycle where it happens, as a wrong phase code, and a second time as a wrong save write or a wrong handler fetch address a few cycles later.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_IND   = 2'd1,
    PH_EXEC  = 2'd2,
    PH_INTR  = 2'd3
  } phase_e;

  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_LOAD  = 3'd0;
  localparam logic [OP_W-1:0] OP_STORE = 3'd1;
  localparam logic [OP_W-1:0] OP_JUMP  = 3'd2;
  localparam logic [OP_W-1:0] OP_IEN   = 3'd3;

  // last step index of the execute subcycle for a given opcode
  function automatic logic [1:0] exec_last(input logic [OP_W-1:0] op);
    case (op)
      OP_LOAD:  exec_last = 2'd3;
      OP_STORE: exec_last = 2'd2;
      default:  exec_last = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/icc_sequencer.sv
module icc_sequencer
  import icc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ind_flag_i,
  input  logic [OP_W-1:0] opcode_i,
  input  logic            irq_i,
  input  logic            ien_i,
  output phase_e          phase_o,
  output logic [1:0]      step_o
);

  localparam logic [1:0] FETCH_LAST = 2'd3;
  localparam logic [1:0] IND_LAST   = 2'd2;
  localparam logic [1:0] INTR_LAST  = 2'd1;

  phase_e     phase_q, phase_d;
  logic [1:0] step_q, step_d;

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q + 2'd1;
    case (phase_q)
      PH_FETCH: if (step_q == FETCH_LAST) begin
        phase_d = ind_flag_i ? PH_IND : PH_EXEC;
        step_d  = 2'd0;
      end
      PH_IND: if (step_q == IND_LAST) begin
        phase_d = PH_EXEC;
        step_d  = 2'd0;
      end
      PH_EXEC: if (step_q == exec_last(opcode_i)) begin
        phase_d = (irq_i && ien_i) ? PH_INTR : PH_FETCH;
        step_d  = 2'd0;
      end
      PH_INTR: if (step_q == INTR_LAST) begin
        phase_d = PH_FETCH;
        step_d  = 2'd0;
      end
      default: begin
        phase_d = PH_FETCH;
        step_d  = 2'd0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      step_q  <= 2'd0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
    end
  end

  assign phase_o = phase_q;
  assign step_o  = step_q;

  // R9
  ind_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IND && $past(phase_q) != PH_IND) |-> $past(phase_q) == PH_FETCH);

  // R9
  exec_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXEC && $past(phase_q) != PH_EXEC) |->
      ($past(phase_q) == PH_FETCH || $past(phase_q) == PH_IND));

  // R7
  intr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_INTR && $past(phase_q) != PH_INTR) |->
      ($past(phase_q) == PH_EXEC && $past(irq_i) && $past(ien_i)));

endmodule

// File: rtl/icc_datapath.sv
module icc_datapath
  import icc_pkg::*;
#(
  parameter int              DATA_W       = 16,
  parameter int              ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'h0FE,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h0C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_i,
  input  logic [1:0]        step_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              ind_flag_o,
  output logic [OP_W-1:0]   opcode_o,
  output logic              ien_o
);

  localparam int IND_BIT = ADDR_W;
  localparam int PAD_W   = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d;
  logic [DATA_W-1:0] mbr_q, mbr_d, ir_q, ir_d, acc_q, acc_d;
  logic              ien_q, ien_d;
  logic              pc_en, mar_en, mbr_en, ir_en, acc_en, ien_en;
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] ea;

  assign op = ir_q[DATA_W-1 -: OP_W];
  assign ea = mbr_q[ADDR_W-1:0];

  always_comb begin
    pc_en = 1'b0;  pc_d  = pc_q;
    mar_en = 1'b0; mar_d = mar_q;
    mbr_en = 1'b0; mbr_d = mbr_q;
    ir_en = 1'b0;  ir_d  = ir_q;
    acc_en = 1'b0; acc_d = acc_q;
    ien_en = 1'b0; ien_d = ien_q;
    mem_rd_o = 1'b0;
    mem_wr_o = 1'b0;
    case (phase_i)
      PH_FETCH: case (step_i)
        2'd0: begin mar_en = 1'b1; mar_d = pc_q; end
        2'd1: begin mem_rd_o = 1'b1; pc_en = 1'b1; pc_d = pc_q + 1'b1; end
        2'd2: begin mbr_en = 1'b1; mbr_d = mem_rdata_i; end
        default: begin ir_en = 1'b1; ir_d = mbr_q; end
      endcase
      PH_IND: case (step_i)
        2'd0: begin mar_en = 1'b1; mar_d = ea; end
        2'd1: mem_rd_o = 1'b1;
        default: begin mbr_en = 1'b1; mbr_d = mem_rdata_i; end
      endcase
      PH_EXEC: case (step_i)
        2'd0: begin
          mar_en = 1'b1; mar_d = ea;
          if (op == OP_JUMP) begin pc_en = 1'b1; pc_d = ea; end
          if (op == OP_IEN) begin ien_en = 1'b1; ien_d = 1'b1; end
        end
        2'd1: begin
          if (op == OP_LOAD) mem_rd_o = 1'b1;
          if (op == OP_STORE) begin mbr_en = 1'b1; mbr_d = acc_q; end
        end
        2'd2: begin
          if (op == OP_LOAD) begin mbr_en = 1'b1; mbr_d = mem_rdata_i; end
          if (op == OP_STORE) mem_wr_o = 1'b1;
        end
        default: if (op == OP_LOAD) begin acc_en = 1'b1; acc_d = mbr_q; end
      endcase
      PH_INTR: case (step_i)
        2'd0: begin
          mbr_en = 1'b1; mbr_d = {{PAD_W{1'b0}}, pc_q};
          mar_en = 1'b1; mar_d = SAVE_ADDR;
        end
        default: begin
          mem_wr_o = 1'b1;
          pc_en = 1'b1;  pc_d  = HANDLER_ADDR;
          ien_en = 1'b1; ien_d = 1'b0;
        end
      endcase
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      ien_q <= 1'b0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (mar_en) mar_q <= mar_d;
      if (mbr_en) mbr_q <= mbr_d;
      if (ir_en)  ir_q  <= ir_d;
      if (acc_en) acc_q <= acc_d;
      if (ien_en) ien_q <= ien_d;
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mbr_q;
  assign ind_flag_o  = mbr_q[IND_BIT];
  assign opcode_o    = op;
  assign ien_o       = ien_q;

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_FETCH && step_i == 2'd1) |=> pc_q == $past(pc_q) + 1'b1);

  // R3
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> (mbr_en && mbr_d == mem_rdata_i));

  // R7
  handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_INTR && mem_wr_o) |=> (pc_q == HANDLER_ADDR && !ien_q));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

endmodule

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl
  import icc_pkg::*;
#(
  parameter int                DATA_W       = 16,
  parameter int                ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'h0FE,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h0C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_pending,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [1:0]        phase_o
);

  phase_e          phase;
  logic [1:0]      step;
  logic            ind_flag;
  logic            ien;
  logic [OP_W-1:0] opcode;

  icc_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ind_flag_i (ind_flag),
    .opcode_i   (opcode),
    .irq_i      (irq_pending),
    .ien_i      (ien),
    .phase_o    (phase),
    .step_o     (step)
  );

  icc_datapath #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .SAVE_ADDR    (SAVE_ADDR),
    .HANDLER_ADDR (HANDLER_ADDR)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_i     (phase),
    .step_i      (step),
    .mem_rdata_i (mem_rdata),
    .mem_addr_o  (mem_addr),
    .mem_rd_o    (mem_rd),
    .mem_wr_o    (mem_wr),
    .mem_wdata_o (mem_wdata),
    .ind_flag_o  (ind_flag),
    .opcode_o    (opcode),
    .ien_o       (ien)
  );

  assign phase_o = phase;

endmodule

// File: tb/instr_cycle_ctrl_tb_top.sv
module instr_cycle_ctrl_tb_top;

  localparam int K_PH = 0;
  localparam int K_FA = 1;
  localparam int K_WR = 2;

  typedef struct {
    int          kind;
    logic [11:0] addr;
    logic [15:0] data;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_pending;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [1:0]  phase_o;

  logic [15:0] mem [256];
  item_t       exp_q[$];
  string       tag_q[$];
  int          checks = 0;
  int          fails  = 0;
  logic [1:0]  prev_ph = 2'd3;
  bit          sb_done = 1'b0;

  always #2 clk = ~clk;

  instr_cycle_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_pending (irq_pending),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .phase_o     (phase_o)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  function automatic logic [15:0] enc(input logic [2:0] op, input logic ind,
                                      input logic [11:0] a);
    return {op, ind, a};
  endfunction

  task automatic push(input int k, input logic [11:0] a, input logic [15:0] d,
                      input string tag);
    item_t it;
    it.kind = k; it.addr = a; it.data = d;
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  // driver: expected events for one instruction up to the end of execute
  task automatic ex_instr(input logic [11:0] a, input logic ind);
    push(K_PH, 12'd0, 16'd0, "R9 fetch");
    push(K_FA, a, 16'd0, "R2 fetch address");
    if (ind) push(K_PH, 12'd1, 16'd0, "R4 indirect");
    push(K_PH, 12'd2, 16'd0, "R9 execute");
  endtask

  task automatic cmp(input int k, input logic [11:0] a, input logic [15:0] d);
    item_t e;
    string t;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    if (e.kind != k || e.addr != a || (k == K_WR && e.data != d)) begin
      fails++;
      $display("FAIL %s: actual kind=%0d addr=%h data=%h, expected kind=%0d addr=%h data=%h",
               t, k, a, d, e.kind, e.addr, e.data);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !sb_done) begin
      if (phase_o != prev_ph) cmp(K_PH, {10'd0, phase_o}, 16'd0);
      prev_ph = phase_o;
      if (mem_rd && phase_o == 2'd0) cmp(K_FA, mem_addr, 16'd0);
      if (mem_wr) cmp(K_WR, mem_addr, mem_wdata);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    int cyc;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    // program: LOAD=0 STORE=1 JUMP=2 IEN=3, bit12 indirect
    mem[8'h00] = enc(3'd0, 1'b0, 12'h040);
    mem[8'h01] = enc(3'd1, 1'b0, 12'h041);
    mem[8'h02] = enc(3'd0, 1'b1, 12'h042);
    mem[8'h03] = enc(3'd1, 1'b1, 12'h044);
    mem[8'h04] = enc(3'd2, 1'b0, 12'h010);
    mem[8'h10] = enc(3'd3, 1'b0, 12'h000);
    mem[8'h11] = enc(3'd1, 1'b0, 12'h049);
    mem[8'hC0] = enc(3'd1, 1'b0, 12'h050);
    mem[8'hC1] = enc(3'd2, 1'b1, 12'h046);
    mem[8'h20] = enc(3'd0, 1'b0, 12'h047);
    mem[8'h21] = enc(3'd1, 1'b0, 12'h048);
    mem[8'h22] = enc(3'd2, 1'b0, 12'h022);
    mem[8'h40] = 16'h1234;
    mem[8'h42] = 16'h0043;
    mem[8'h43] = 16'hBEEF;
    mem[8'h44] = 16'h0045;
    mem[8'h46] = 16'h0020;
    mem[8'h47] = 16'h5A5A;

    // expected event stream (request held high from the start)
    ex_instr(12'h000, 1'b0);
    ex_instr(12'h001, 1'b0);
    push(K_WR, 12'h041, 16'h1234, "R5 store direct");
    ex_instr(12'h002, 1'b1);
    ex_instr(12'h003, 1'b1);
    push(K_WR, 12'h045, 16'hBEEF, "R4 indirect store after indirect load");
    ex_instr(12'h004, 1'b0);
    ex_instr(12'h010, 1'b0);
    ex_instr(12'h011, 1'b0);
    push(K_WR, 12'h049, 16'hBEEF, "R8 no interrupt right after enable");
    push(K_PH, 12'd3, 16'd0, "R7 interrupt entry");
    push(K_WR, 12'h0FE, 16'h0012, "R7 return address save");
    ex_instr(12'h0C0, 1'b0);
    push(K_WR, 12'h050, 16'hBEEF, "R8 disabled after entry");
    ex_instr(12'h0C1, 1'b1);
    ex_instr(12'h020, 1'b0);
    ex_instr(12'h021, 1'b0);
    push(K_WR, 12'h048, 16'h5A5A, "R6 jump indirect target then R5 load");
    ex_instr(12'h022, 1'b0);

    rst_n = 1'b0;
    irq_pending = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(phase_o == 2'd0, "R1 phase in reset", phase_o, 0);
    chk(!mem_rd, "R1 read strobe in reset", mem_rd, 0);
    chk(!mem_wr, "R1 write strobe in reset", mem_wr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(phase_o == 2'd0 && !mem_wr, "R1 state after release", phase_o, 0);

    cyc = 0;
    while (exp_q.size() != 0 && cyc < 5000) begin
      @(posedge clk);
      cyc++;
      // R10 strobes exclusive
      if (mem_rd && mem_wr) chk(1'b0, "R10 both strobes", 1, 0);
    end
    sb_done = 1'b1;
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d items left, expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule